// File: doc/BRIEF.md
# Read-Modify-Write Operation Unit

This unit performs a single-operand byte operation on one location, and the location is either memory or a CPU register. A memory target gets one read on a synchronous memory port, then one modify cycle, then a write-back to the address that was read. A register target takes its operand from `opnd_i`. Its result goes out on the register write port, and it uses no bus cycles. The unit also keeps the negative, zero and carry condition flags.

A sequencer gives the unit an operation code, a target kind, an address and a bit number, and pulses `start_i`. The current carry comes in on `c_i`. The unit answers with a `done_o` pulse. That pulse comes with `err_o` when the request is illegal. The updated flags are visible from the `done_o` cycle onward. Opcode decode and indexed address arithmetic happen before this block.

Top module: `rmw_unit`

## Requirements
- R1: A memory request started in cycle k drives `mem_re_o` in cycle k+1 and drives `done_o` in cycle k+3. For every operation except test, `mem_we_o` is high in cycle k+3, at the same address as the read, with the result on `mem_wdata_o`. There is exactly one read.
- R2: A register request (`tgt_i` = 2 or 3) gives `done_o` in cycle k+1 with no memory read or write. `reg_we_o` is high with the result on `reg_wdata_o`, except for test.
- R3: The operation codes are 0 shift left, 1 arithmetic shift right, 9 logical shift right, 11 rotate left and 12 rotate right. The bit shifted out goes to carry. Rotates fill the vacated bit with the incoming carry `c_i`. Arithmetic shift right keeps bit 7.
- R4: Code 8 (logical shift left) gives the same result and the same flags as code 0.
- R5: The remaining operation codes are 4 clear, 5 one's complement, 6 decrement, 7 increment and 10 two's complement negate. Complement sets carry to 1. Negate sets carry when the result is nonzero. Clear, decrement and increment load carry from `c_i`.
- R6: For every operation except bit set and bit clear, the negative flag is bit 7 of the result and the zero flag is set when the result is 0x00.
- R7: Code 13 (test) updates N and Z from the operand and loads carry from `c_i`. It never asserts `mem_we_o` or `reg_we_o`.
- R8: Code 2 (bit clear) and code 3 (bit set) change only bit `bit_i` of the operand and leave all three flags unchanged.
- R9: Bit set or bit clear with a target other than direct (`tgt_i` = 0) is rejected, and so are codes 14 and 15. A rejected request gives `done_o` with `err_o` in cycle k+1, makes no bus cycle and no register write, and leaves the flags unchanged.
- R10: A direct target (`tgt_i` = 0) forces the upper address byte to zero on `mem_addr_o`. An extended target (`tgt_i` = 1) uses `addr_i` unchanged.
- R11: After reset all outputs that are strobes are low and N, Z and C are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when idle |
| op_i | input | 4 | Operation code |
| tgt_i | input | 2 | 0 direct, 1 extended, 2/3 register |
| addr_i | input | 16 | Operand address |
| bit_i | input | 3 | Bit number for bit set/clear |
| c_i | input | 1 | Incoming carry |
| opnd_i | input | 8 | Register operand |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after the read strobe |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Request rejected, with done |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
The bench counts clock cycles from the start cycle and requires `done_o` exactly one cycle later for register and rejected requests and three cycles later for memory requests. The write strobe, address, data and flags are compared in that same done cycle. A monitor counts read strobes between start and done, and any write strobe outside a done cycle is an error. Every operation is swept over all operand values with both carry inputs.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,  OP_ASR  = 4'd1,  OP_BCLR = 4'd2,  OP_BSET = 4'd3,
    OP_CLR  = 4'd4,  OP_COM  = 4'd5,  OP_DEC  = 4'd6,  OP_INC  = 4'd7,
    OP_SHL2 = 4'd8,  OP_LSR  = 4'd9,  OP_NEG  = 4'd10, OP_ROL  = 4'd11,
    OP_ROR  = 4'd12, OP_TST  = 4'd13
  } rmw_op_e;

  typedef enum logic [1:0] {
    TGT_DIR = 2'd0, TGT_EXT = 2'd1, TGT_RA = 2'd2, TGT_RB = 2'd3
  } rmw_tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RD, ST_MOD, ST_FIN
  } rmw_st_e;

  localparam int unsigned OP_LAST = 13;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          cin_i,
  input  logic [BW-1:0] bit_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          flg_upd_o
);
  always_comb begin
    res_o     = opnd_i;
    cout_o    = cin_i;
    flg_upd_o = 1'b1;
    unique case (op_i)
      OP_SHL, OP_SHL2: begin
        res_o  = {opnd_i[DW-2:0], 1'b0};
        cout_o = opnd_i[DW-1];
      end
      OP_ASR: begin
        res_o  = {opnd_i[DW-1], opnd_i[DW-1:1]};
        cout_o = opnd_i[0];
      end
      OP_LSR: begin
        res_o  = {1'b0, opnd_i[DW-1:1]};
        cout_o = opnd_i[0];
      end
      OP_ROL: begin
        res_o  = {opnd_i[DW-2:0], cin_i};
        cout_o = opnd_i[DW-1];
      end
      OP_ROR: begin
        res_o  = {cin_i, opnd_i[DW-1:1]};
        cout_o = opnd_i[0];
      end
      OP_BCLR: begin
        res_o[bit_i] = 1'b0;
        flg_upd_o    = 1'b0;
      end
      OP_BSET: begin
        res_o[bit_i] = 1'b1;
        flg_upd_o    = 1'b0;
      end
      OP_CLR: res_o = '0;
      OP_COM: begin
        res_o  = ~opnd_i;
        cout_o = 1'b1;
      end
      OP_DEC: res_o = opnd_i - 1'b1;
      OP_INC: res_o = opnd_i + 1'b1;
      OP_NEG: begin
        res_o  = '0 - opnd_i;
        cout_o = |opnd_i;
      end
      OP_TST: res_o = opnd_i;
      default: flg_upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 16,
  parameter int unsigned ZPW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    tgt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  input  logic          c_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] mem_rdata_i,
  // to alu
  output logic [3:0]    alu_op_o,
  output logic [DW-1:0] alu_opnd_o,
  output logic          alu_cin_o,
  output logic [BW-1:0] alu_bit_o,
  output logic          cap_o,
  // bus / completion
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          reg_we_o,
  output logic          done_o,
  output logic          err_o
);
  rmw_st_e       st_q, st_d;
  logic [3:0]    op_q;
  logic [BW-1:0] bit_q;
  logic          c_q, mem_q, err_q;
  logic [AW-1:0] addr_q;

  logic live, is_bit, is_reg, illegal, accept;

  assign live    = (st_q == ST_IDLE);
  assign accept  = live && start_i;
  assign is_bit  = (op_i == OP_BCLR) || (op_i == OP_BSET);
  assign is_reg  = (tgt_i == TGT_RA) || (tgt_i == TGT_RB);
  assign illegal = (op_i > 4'(OP_LAST)) || (is_bit && (tgt_i != TGT_DIR));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = (illegal || is_reg) ? ST_FIN : ST_RD;
      ST_RD:   st_d = ST_MOD;
      ST_MOD:  st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      bit_q  <= '0;
      c_q    <= 1'b0;
      mem_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q   <= op_i;
        bit_q  <= bit_i;
        c_q    <= c_i;
        mem_q  <= !is_reg && !illegal;
        err_q  <= illegal;
        addr_q <= (tgt_i == TGT_DIR) ? {{(AW-ZPW){1'b0}}, addr_i[ZPW-1:0]} : addr_i;
      end
    end
  end

  // register operands are processed in the start cycle, memory ones in the modify cycle
  assign alu_op_o   = live ? op_i  : op_q;
  assign alu_bit_o  = live ? bit_i : bit_q;
  assign alu_cin_o  = live ? c_i   : c_q;
  assign alu_opnd_o = live ? opnd_i : mem_rdata_i;
  assign cap_o      = (accept && is_reg && !illegal) || (st_q == ST_MOD);

  assign mem_re_o   = (st_q == ST_RD);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == ST_FIN);
  assign err_o      = done_o && err_q;
  assign mem_we_o   = done_o && mem_q && (op_q != OP_TST);
  assign reg_we_o   = done_o && !mem_q && !err_q && (op_q != OP_TST);

  p_no_rw_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_write_after_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_re_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));
  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_reg_no_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (!$past(mem_re_o) && !mem_we_o));
  p_reject_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!$past(mem_re_o) && !mem_we_o && !reg_we_o));
  p_tst_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_TST) |-> !(mem_we_o || reg_we_o));
endmodule

// File: rtl/rmw_flags.sv
module rmw_flags
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic          flg_upd_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o
);
  logic [DW-1:0] res_q;
  logic          n_q, z_q, c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else if (cap_i) begin
      res_q <= res_i;
      if (flg_upd_i) begin
        n_q <= res_i[DW-1];
        z_q <= ~|res_i;
        c_q <= cout_i;
      end
    end
  end

  assign res_o = res_q;
  assign n_o   = n_q;
  assign z_o   = z_q;
  assign c_o   = c_q;

  p_bit_flags_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !flg_upd_i) |=> ($stable(n_q) && $stable(z_q) && $stable(c_q)));
  p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && flg_upd_i) |=> (z_q == (res_q == '0) && n_q == res_q[DW-1]));
  p_no_cap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(res_q) && $stable(c_q)));
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 16,
  parameter int unsigned ZPW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    tgt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  input  logic          c_i,
  input  logic [DW-1:0] opnd_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o
);
  logic [3:0]    alu_op;
  logic [DW-1:0] alu_opnd, alu_res, res_q;
  logic          alu_cin, alu_cout, alu_upd, cap;
  logic [BW-1:0] alu_bit;

  rmw_ctrl #(.DW(DW), .AW(AW), .ZPW(ZPW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i, .tgt_i, .addr_i, .bit_i, .c_i, .opnd_i,
    .mem_rdata_i,
    .alu_op_o(alu_op), .alu_opnd_o(alu_opnd), .alu_cin_o(alu_cin),
    .alu_bit_o(alu_bit), .cap_o(cap),
    .mem_re_o, .mem_we_o, .mem_addr_o, .reg_we_o, .done_o, .err_o
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op_i(alu_op), .opnd_i(alu_opnd), .cin_i(alu_cin), .bit_i(alu_bit),
    .res_o(alu_res), .cout_o(alu_cout), .flg_upd_o(alu_upd)
  );

  rmw_flags #(.DW(DW)) u_flags (
    .clk_i, .rst_ni, .cap_i(cap), .res_i(alu_res), .cout_i(alu_cout),
    .flg_upd_i(alu_upd), .res_o(res_q), .n_o, .z_o, .c_o
  );

  assign mem_wdata_o = res_q;
  assign reg_wdata_o = res_q;
endmodule

// File: tb/sim_rmw_unit.sv
module sim_rmw_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start_i = 0, c_i = 0;
  logic [3:0]  op_i = 0;
  logic [1:0]  tgt_i = 0;
  logic [15:0] addr_i = 0;
  logic [2:0]  bit_i = 0;
  logic [7:0]  opnd_i = 0, mem_rdata = 0;
  logic        mem_re, mem_we, reg_we, done, err, n_o, z_o, c_o;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, reg_wdata;

  rmw_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .op_i, .tgt_i, .addr_i, .bit_i, .c_i,
    .opnd_i, .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .reg_we_o(reg_we),
    .reg_wdata_o(reg_wdata), .done_o(done), .err_o(err), .n_o, .z_o, .c_o
  );

  typedef struct {
    int         lat, start_cyc, rds;
    bit         err, wr_mem, wr_reg, n, z, c;
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, cyc = 0, rd_cnt = 0;
  bit m_n = 0, m_z = 0, m_c = 0;
  logic [7:0] mem [0:255];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model
  task automatic model(input int op, input int v, input bit cin, input int b,
                       output int r, output bit c, output bit upd);
    int t;
    c = cin; upd = 1; r = v;
    case (op)
      0, 8: begin t = v * 2; r = t % 256; c = (t > 255); end
      1:  begin r = (v / 2) + (v >= 128 ? 128 : 0); c = v % 2; end
      9:  begin r = v / 2; c = v % 2; end
      11: begin r = (v * 2 + cin) % 256; c = (v >= 128); end
      12: begin r = v / 2 + (cin ? 128 : 0); c = v % 2; end
      2:  begin r = v & (255 - (1 << b)); upd = 0; end
      3:  begin r = v | (1 << b); upd = 0; end
      4:  r = 0;
      5:  begin r = 255 - v; c = 1; end
      6:  r = (v + 255) % 256;
      7:  r = (v + 1) % 256;
      10: begin r = (256 - v) % 256; c = (v != 0); end
      13: r = v;
      default: upd = 0;
    endcase
  endtask

  task automatic run(input int op, input int tgt, input int addr, input int b,
                     input int v, input bit cin, input string req);
    exp_t e;
    int r; bit c, upd, rej, isreg;
    model(op, v, cin, b, r, c, upd);
    isreg = (tgt >= 2);
    rej   = (op > 13) || ((op == 2 || op == 3) && tgt != 0);
    @(negedge clk);
    if (!isreg) mem[addr % 256] = v[7:0];
    op_i = op[3:0]; tgt_i = tgt[1:0]; addr_i = addr[15:0]; bit_i = b[2:0];
    c_i = cin; opnd_i = isreg ? v[7:0] : 8'hxx; start_i = 1;
    rd_cnt = 0;
    if (!rej && upd) begin m_n = (r >= 128); m_z = (r == 0); m_c = c; end
    e.req = req; e.start_cyc = cyc; e.err = rej;
    e.lat = (rej || isreg) ? 1 : 3;
    e.rds = (rej || isreg) ? 0 : 1;
    e.wr_mem = !rej && !isreg && op != 13;
    e.wr_reg = !rej && isreg && op != 13;
    e.addr = (tgt == 0) ? {8'h00, addr[7:0]} : addr[15:0];
    e.data = r[7:0]; e.n = m_n; e.z = m_z; e.c = m_c;
    q.push_back(e);
    @(negedge clk);
    start_i = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (mem_re) rd_cnt++;
    if (mem_we && !done) chk(0, "R1 stray write", 1, 0);
    if (done) begin
      if (q.size() == 0) chk(0, "R1 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - e.start_cyc == e.lat, {e.req, " latency"}, cyc - e.start_cyc, e.lat);
        chk(err == e.err, {e.req, " R9 err"}, err, e.err);
        chk(mem_we == e.wr_mem, {e.req, " mem_we"}, mem_we, e.wr_mem);
        chk(reg_we == e.wr_reg, {e.req, " reg_we"}, reg_we, e.wr_reg);
        chk(rd_cnt == e.rds, {e.req, " reads"}, rd_cnt, e.rds);
        if (e.wr_mem) begin
          chk(mem_addr == e.addr, {e.req, " R10 addr"}, mem_addr, e.addr);
          chk(mem_wdata == e.data, {e.req, " wdata"}, mem_wdata, e.data);
        end
        if (e.wr_reg) chk(reg_wdata == e.data, {e.req, " rdata"}, reg_wdata, e.data);
        chk({n_o, z_o, c_o} == {e.n, e.z, e.c}, {e.req, " R6 flags"},
            {n_o, z_o, c_o}, {e.n, e.z, e.c});
      end
    end
  end

  initial begin : wdog
    wait (cyc > 150000);
    chk(0, "watchdog", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic string tag(input int op);
    case (op)
      0, 1, 9, 11, 12: return "R3";
      8:               return "R4";
      2, 3:            return "R8";
      13:              return "R7";
      default:         return "R5";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({mem_re, mem_we, reg_we, done, err} == 5'b0, "R11 strobes", {mem_re, mem_we, reg_we, done, err}, 0);
    chk({n_o, z_o, c_o} == 3'b0, "R11 flags", {n_o, z_o, c_o}, 0);
    rst_n = 1;
    // R2 full register sweep
    for (int op = 0; op < 14; op++)
      for (int v = 0; v < 256; v++)
        for (int ci = 0; ci < 2; ci++)
          run(op, 2 + (v % 2), 0, v % 8, v, ci[0], {tag(op), " R2 reg"});
    // R1 memory, direct and extended
    for (int op = 0; op < 14; op++)
      for (int i = 0; i < 6; i++) begin
        run(op, 0, 16'hAB10 + i, i, (i * 53 + 128 * (i % 2)) % 256, i[0], {tag(op), " R1 R10 direct"});
        run(op, 1, 16'h1230 + i, i, (i * 91 + 7) % 256, ~i[0], {tag(op), " R1 R10 ext"});
      end
    // R9 rejects
    run(3, 2, 0, 4, 8'h10, 1, "R9 bset reg");
    run(2, 1, 16'h3344, 1, 8'hFF, 0, "R9 bclr ext");
    run(14, 2, 0, 0, 8'h55, 1, "R9 op14");
    run(15, 0, 16'h0005, 0, 8'h80, 0, "R9 op15");
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule